// File: doc/BRIEF.md
# Dual Lookup-Table Logic Cell

This block is a single programmable logic cell. It holds two 16-entry, one-bit lookup tables. Each table is addressed by its own four inputs, and these inputs are read as a binary number with input bit 0 as the least significant bit. In the default arrangement the cell produces two unrelated 4-input functions. When the fuse option is set, the first output instead selects between the two tables with a fifth input, so the first output can realise any 5-input function. Each output can come straight from the table logic or from an output flip-flop, and this choice is made separately for each output. The flip-flops share a clock enable and a synchronous clear.

The table contents and the mode word are written through a simple load port. The cell can also be put into a memory mode. In that mode each table acts as a 16x1 RAM: its four inputs form the address, the write is synchronous and the read is asynchronous. While the cell is in memory mode, load-port writes are dropped, so memory mode can only be left through reset. The cell reset is asynchronous and active low. Its release is synchronised inside the cell.

Top module: `lut_cell`

## Requirements
- R1: While reset is asserted and right after it, both tables hold zero, the mode word is zero (independent, logic mode, both outputs bypassed), the output flip-flops hold 0, and so both outputs read 0.
- R2: With fuse clear, out_f equals bit in_f of table F and out_g equals bit in_g of table G. The address bit 0 is the least significant bit, and in_h has no effect.
- R3: With fuse set, out_f equals bit in_f of table G when in_h is 1 and bit in_f of table F when in_h is 0. out_g still equals bit in_g of table G.
- R4: A load (cfg_we high at a clock edge) writes cfg_word into table F when cfg_sel is 0 and into table G when cfg_sel is 1. The same load writes the mode word from cfg_mode: bit 0 is fuse, bit 1 is memory mode, bit 2 registers out_f, bit 3 registers out_g. The result is visible right after that edge.
- R5: An output whose register bit is 0 follows the table logic in the same cycle, with no clock latency.
- R6: An output whose register bit is 1 shows a flip-flop. At each edge where out_ce is 1 and out_srst is 0, the flip-flop captures the logic value. When out_ce is 0 it holds its value.
- R7: out_srst high at an edge clears the output flip-flops to 0, whatever the value of out_ce.
- R8: In memory mode, ram_we_f writes ram_din_f into bit in_f of table F at the edge, and ram_we_g writes ram_din_g into bit in_g of table G. The new value reads out without further delay.
- R9: Outside memory mode, ram_we_f and ram_we_g have no effect on the tables.
- R10: In memory mode, loads change neither the tables nor the mode word.
- R11: When rst_n is low the cell is reset at once. After rst_n rises, the first two clock edges are still treated as reset, and the cell acts on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for table word and mode |
| cfg_sel | input | 1 | Table to load: 0 = F, 1 = G |
| cfg_word | input | 16 | Table contents, bit k is entry k |
| cfg_mode | input | 4 | Mode word {reg_g, reg_f, mem, fuse} |
| in_f | input | 4 | Address inputs of table F |
| in_g | input | 4 | Address inputs of table G |
| in_h | input | 1 | Fifth input, selects the table in fuse mode |
| ram_we_f | input | 1 | Memory-mode write enable, table F |
| ram_din_f | input | 1 | Memory-mode write data, table F |
| ram_we_g | input | 1 | Memory-mode write enable, table G |
| ram_din_g | input | 1 | Memory-mode write data, table G |
| out_ce | input | 1 | Output flip-flop clock enable |
| out_srst | input | 1 | Output flip-flop synchronous clear |
| out_f | output | 1 | First output |
| out_g | output | 1 | Second output |

## Verification
Bypassed outputs, and memory reads, depend only on the inputs and on stored state. The bench therefore changes the inputs on the falling edge and checks them a quarter period later, within the same cycle. Loads and memory writes take effect at the next rising edge, so their results are checked in the low half-cycle that follows that edge. A registered output is checked twice: once before the capturing edge, where it must still show the old value, and once after it. After a reset release the bench counts two edges in which a load must have no effect, and checks that a load on the third edge does take effect.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned NTAB   = 2;

  typedef struct packed {
    logic reg_g;
    logic reg_f;
    logic mem;
    logic fuse;
  } cell_mode_t;
endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lut_table.sv
module lut_table
  import lut_cell_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned NENT = 1 << AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ram_mode,
  input  logic            ld_en,
  input  logic [NENT-1:0] ld_word,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic            wr_din,
  input  logic [AW-1:0]   rd_addr_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic            rd_a,
  output logic            rd_b
);
  logic [NENT-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (ram_mode) begin
      if (wr_en) mem_d[wr_addr] = wr_din;
    end else if (ld_en) begin
      mem_d = ld_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign rd_a = mem_q[rd_addr_a];
  assign rd_b = mem_q[rd_addr_b];

  // R8
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mode && wr_en) |=> mem_q[$past(wr_addr)] == $past(wr_din));
  // R9
  ram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_mode && !ld_en) |=> $stable(mem_q));
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mode && !wr_en) |=> $stable(mem_q));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_mode && ld_en) |=> mem_q == $past(ld_word));
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic use_reg,
  input  logic ce,
  input  logic srst,
  input  logic d,
  output logic q
);
  logic r_q, r_d;

  always_comb begin
    r_d = r_q;
    if (srst)    r_d = 1'b0;
    else if (ce) r_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= 1'b0;
    else        r_q <= r_d;
  end

  assign q = use_reg ? r_q : d;

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst) |=> r_q == $past(d));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !srst) |=> $stable(r_q));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !r_q);
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_word,
  input  logic [3:0]  cfg_mode,
  input  logic [3:0]  in_f,
  input  logic [3:0]  in_g,
  input  logic        in_h,
  input  logic        ram_we_f,
  input  logic        ram_din_f,
  input  logic        ram_we_g,
  input  logic        ram_din_g,
  input  logic        out_ce,
  input  logic        out_srst,
  output logic        out_f,
  output logic        out_g
);
  logic       rst_i_n;
  cell_mode_t mode_q, mode_d;

  logic [NTAB-1:0]        ld_en, wr_en, wr_din, rd_a, rd_b, logic_v, use_reg, q_v;
  logic [ADDR_W-1:0]      addr_own [NTAB];

  lut_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  always_comb begin
    mode_d = mode_q;
    if (cfg_we && !mode_q.mem) mode_d = cell_mode_t'(cfg_mode);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= '0;
    else          mode_q <= mode_d;
  end

  assign addr_own[0] = in_f;
  assign addr_own[1] = in_g;
  assign wr_en       = {ram_we_g, ram_we_f};
  assign wr_din      = {ram_din_g, ram_din_f};
  assign use_reg     = {mode_q.reg_g, mode_q.reg_f};

  generate
    for (genvar t = 0; t < NTAB; t++) begin : g_tab
      assign ld_en[t] = cfg_we && !mode_q.mem && (cfg_sel == 1'(t));
      lut_table #(.AW(ADDR_W)) u_tab (
        .clk(clk), .rst_n(rst_i_n), .ram_mode(mode_q.mem),
        .ld_en(ld_en[t]), .ld_word(cfg_word),
        .wr_en(wr_en[t]), .wr_addr(addr_own[t]), .wr_din(wr_din[t]),
        .rd_addr_a(addr_own[t]), .rd_addr_b(in_f),
        .rd_a(rd_a[t]), .rd_b(rd_b[t])
      );
      lut_out_stage u_out (
        .clk(clk), .rst_n(rst_i_n), .use_reg(use_reg[t]),
        .ce(out_ce), .srst(out_srst), .d(logic_v[t]), .q(q_v[t])
      );
    end
  endgenerate

  // fused path: fifth input picks G over F, both addressed by in_f
  assign logic_v[0] = mode_q.fuse ? (in_h ? rd_b[1] : rd_a[0]) : rd_a[0];
  assign logic_v[1] = rd_a[1];

  assign out_f = q_v[0];
  assign out_g = q_v[1];

  // R10
  mem_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mode_q.mem |=> mode_q.mem);
  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_we && !mode_q.mem) |=> mode_q == $past(cell_mode_t'(cfg_mode)));
  // R11
  rst_hold_chk: assert property (@(posedge clk)
    !rst_n |=> !rst_i_n);
endmodule

// File: tb/lut_cell_test.sv
module lut_cell_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [3:0]  cfg_mode = '0;
  logic [3:0]  in_f = '0, in_g = '0;
  logic        in_h = 1'b0;
  logic        ram_we_f = 1'b0, ram_din_f = 1'b0, ram_we_g = 1'b0, ram_din_g = 1'b0;
  logic        out_ce = 1'b0, out_srst = 1'b0;
  logic        out_f, out_g;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [15:0] TF = 16'hA5C3;
  localparam logic [15:0] TG = 16'h3C96;

  // {fuse, in_f, in_g, in_h, exp_f, exp_g}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 4'd0,  4'd0,  1'b0, 1'b1, 1'b0},
    {1'b0, 4'd5,  4'd9,  1'b0, 1'b0, 1'b0},
    {1'b0, 4'd6,  4'd12, 1'b1, 1'b1, 1'b1},
    {1'b0, 4'd13, 4'd2,  1'b0, 1'b1, 1'b1},
    {1'b0, 4'd8,  4'd15, 1'b0, 1'b1, 1'b0},
    {1'b1, 4'd2,  4'd1,  1'b0, 1'b0, 1'b1},
    {1'b1, 4'd2,  4'd1,  1'b1, 1'b1, 1'b1},
    {1'b1, 4'd4,  4'd7,  1'b1, 1'b1, 1'b1},
    {1'b1, 4'd4,  4'd7,  1'b0, 1'b0, 1'b1},
    {1'b1, 4'd11, 4'd10, 1'b1, 1'b1, 1'b1},
    {1'b1, 4'd11, 4'd3,  1'b0, 1'b0, 1'b0},
    {1'b1, 4'd14, 4'd14, 1'b1, 1'b0, 1'b0}
  };

  lut_cell uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive a load across one rising edge; returns in the low phase after it
  task automatic load(input logic sel, input logic [15:0] w, input logic [3:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_word = w; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    #5;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    in_f = 4'd3; in_g = 4'd9;
    repeat (2) @(negedge clk);
    check("R1 out_f in reset", out_f, 1'b0);
    check("R1 out_g in reset", out_g, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_f after reset", out_f, 1'b0);
    check("R1 out_g after reset", out_g, 1'b0);

    // R4: load both tables
    load(1'b0, TF, 4'b0000);
    load(1'b1, TG, 4'b0000);

    // R2 / R3 / R5 vector walk
    for (int i = 0; i < NV; i++) begin
      load(1'b0, TF, {3'b000, VEC[i][11]});
      in_f = VEC[i][10:7]; in_g = VEC[i][6:3]; in_h = VEC[i][2];
      settle();
      check(VEC[i][11] ? "R3 out_f fused" : "R2 out_f", out_f, VEC[i][1]);
      check(VEC[i][11] ? "R3 out_g fused" : "R2 out_g", out_g, VEC[i][0]);
    end

    // R5: same-cycle bypass response
    load(1'b0, TF, 4'b0000);
    in_f = 4'd1; settle();
    check("R5 bypass f=1", out_f, 1'b1);
    in_f = 4'd2; #1;
    check("R5 bypass f=0", out_f, 1'b0);

    // R9: ram writes ignored outside memory mode (F[1]=1)
    @(negedge clk);
    in_f = 4'd1; ram_we_f = 1'b1; ram_din_f = 1'b0;
    @(negedge clk);
    ram_we_f = 1'b0; settle();
    check("R9 table F kept", out_f, 1'b1);

    // R6: registered outputs
    load(1'b0, TF, 4'b1100);
    in_f = 4'd0; in_g = 4'd1; out_ce = 1'b1; settle();
    check("R6 out_f before edge", out_f, 1'b0);
    @(negedge clk); settle();
    check("R6 out_f captured", out_f, 1'b1);
    check("R6 out_g captured", out_g, 1'b1);
    out_ce = 1'b0; in_f = 4'd2; in_g = 4'd0;
    @(negedge clk); settle();
    check("R6 out_f held ce=0", out_f, 1'b1);
    check("R6 out_g held ce=0", out_g, 1'b1);

    // R7: clear beats enable
    out_ce = 1'b1; out_srst = 1'b1; in_f = 4'd0;
    @(negedge clk); settle();
    check("R7 out_f cleared", out_f, 1'b0);
    check("R7 out_g cleared", out_g, 1'b0);
    out_srst = 1'b0; out_ce = 1'b0;

    // R8: memory mode writes
    load(1'b0, TF, 4'b0010);
    in_f = 4'd0; in_g = 4'd5; settle();
    check("R8 F[0] before write", out_f, 1'b1);
    check("R8 G[5] before write", out_g, 1'b0);
    ram_we_f = 1'b1; ram_din_f = 1'b0; ram_we_g = 1'b1; ram_din_g = 1'b1;
    @(negedge clk);
    ram_we_f = 1'b0; ram_we_g = 1'b0; settle();
    check("R8 F[0] written", out_f, 1'b0);
    check("R8 G[5] written", out_g, 1'b1);

    // R10: loads dropped in memory mode
    load(1'b0, 16'hFFFF, 4'b0000);
    settle();
    check("R10 table F unchanged", out_f, 1'b0);
    in_f = 4'd3; ram_we_f = 1'b1; ram_din_f = 1'b1;
    @(negedge clk);
    ram_we_f = 1'b0; settle();
    check("R10 mode still memory", out_f, 1'b1);

    // R11: async reset and delayed release
    #2 rst_n = 1'b0; #1;
    check("R11 async clear", out_f, 1'b0);
    @(negedge clk);
    in_f = 4'd0;
    rst_n = 1'b1;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_word = 16'hFFFF; cfg_mode = 4'b0000;
    repeat (2) @(negedge clk);
    cfg_we = 1'b0; settle();
    check("R11 load in release window", out_f, 1'b0);
    load(1'b0, 16'hFFFF, 4'b0000);
    settle();
    check("R11 load after release", out_f, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule